// File: doc/BRIEF.md
# Interval and Compare Timer Channel

This block is one 32-bit timer channel that software drives through a small register window. Software chooses a mode and a compare value, writes a start trigger, and from then on the channel either produces a steady stream of periodic interrupts or acts as a free-running timebase that flags one particular count. A second trigger register halts the channel. A status bit shows whether the counter is running, and the live count can be read in any cycle.

In interval mode the counter loads the compare value at start, counts down to zero, reloads and issues an interrupt pulse, so a compare value of N-1 gives one interrupt every N clocks. In free-running mode the counter starts at zero, counts up, wraps through the full 32-bit range and flags the cycle after it reaches the compare value, without stopping. Mode and compare value are sampled only at the moment a start is accepted, so software can prepare the next setting while the channel runs.

Top module: `ictmr_channel`

## Requirements
- R1: After reset the channel is stopped, the compare, counter, status and control registers all read 0 and `tick_irq` is low.
- R2: The compare register (offset 0x00, 32 bits) reads back what was written; the control register (offset 0x20) keeps only bit 1, and every other control bit reads 0.
- R3: Bit 0 of the status register (offset 0x10) reads 1 while the counter runs and 0 while it is stopped; its other bits read 0.
- R4: A write with bit 0 set to the start register (offset 0x14) starts a stopped channel on that clock edge; a write with bit 0 clear has no effect.
- R5: A write with bit 0 set to the stop register (offset 0x18) stops the channel on that clock edge; the count then holds its last value and `tick_irq` stays low.
- R6: With control bit 1 at 0 (interval mode) the counter (offset 0x04) holds the compare value C right after start, decrements each clock, and after reading 0 reloads C.
- R7: In interval mode `tick_irq` is high for one cycle following each cycle in which the count was 0, so C = N-1 gives one pulse every N clocks (every clock when C is 0).
- R8: With control bit 1 at 1 (free-running mode) the counter reads 0 right after start, increments each clock, keeps counting past the compare value and wraps modulo 2^32.
- R9: In free-running mode `tick_irq` is high for one cycle following each cycle in which the count equals the compare value.
- R10: While running, writes to the compare and control registers and further start writes change neither the count sequence nor the interrupt timing; they take effect at the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter advances once per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle in which it is high |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data; 8-bit registers use the low byte |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_irq | output | 1 | One-cycle interrupt pulse |

## Verification
The checker watches, on every cycle, that the count steps by exactly one in the direction the active mode dictates even while start writes arrive, that a stopped counter holds still, that a stop write clears the running state and the interrupt at once, and that an interrupt only follows a running cycle. What only the bench scenarios can show is the absolute timing: that the count begins at the compare value or at zero, where the interrupt pulses fall relative to the start edge for many compare values, that the free-running counter passes the compare value without halting, and that register values written during a run stay out of the active setting until the next start.

// File: rtl/ictmr_pkg.sv
// Shared constants and types for the interval/compare timer channel.
// Assumes a byte-addressed register window of 2^TMR_ADDR_W bytes.
package ictmr_pkg;
    localparam int TMR_DATA_W = 32;
    localparam int TMR_ADDR_W = 6;

    // Register offsets as seen by software.
    localparam logic [TMR_ADDR_W-1:0] OFS_COMPARE = 6'h00;
    localparam logic [TMR_ADDR_W-1:0] OFS_COUNT   = 6'h04;
    localparam logic [TMR_ADDR_W-1:0] OFS_STATUS  = 6'h10;
    localparam logic [TMR_ADDR_W-1:0] OFS_START   = 6'h14;
    localparam logic [TMR_ADDR_W-1:0] OFS_STOP    = 6'h18;
    localparam logic [TMR_ADDR_W-1:0] OFS_CONTROL = 6'h20;

    // Control register bit that selects the operating mode.
    localparam int CTL_MODE_BIT = 1;

    typedef enum logic {
        MODE_INTERVAL = 1'b0,
        MODE_FREERUN  = 1'b1
    } tmr_mode_e;
endpackage

// File: rtl/ictmr_regs.sv
// Register decode for the timer channel: holds the programmed compare value
// and mode, turns writes to the trigger offsets into single-cycle requests,
// and multiplexes read data. Assumes at most one write per cycle.
module ictmr_regs
    import ictmr_pkg::*;
#(
    parameter int DATA_W = TMR_DATA_W,
    parameter int ADDR_W = TMR_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] count,
    input  logic              running,
    output logic [DATA_W-1:0] cmp_prog,
    output tmr_mode_e         mode_prog,
    output logic              start_req,
    output logic              stop_req,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [DATA_W-1:0] ZERO_WORD = '0;

    // Programmed compare and mode registers, written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_prog  <= ZERO_WORD;
            mode_prog <= MODE_INTERVAL;
        end else if (wr) begin
            if (addr == OFS_COMPARE) cmp_prog <= wdata;
            if (addr == OFS_CONTROL) mode_prog <= tmr_mode_e'(wdata[CTL_MODE_BIT]);
        end
    end

    // Trigger requests: a write with bit 0 set to a trigger offset.
    always_comb begin
        start_req = wr && (addr == OFS_START) && wdata[0];
        stop_req  = wr && (addr == OFS_STOP)  && wdata[0];
    end

    // Read multiplexer; trigger and unmapped offsets read as zero.
    always_comb begin
        rdata = ZERO_WORD;
        case (addr)
            OFS_COMPARE: rdata = cmp_prog;
            OFS_COUNT:   rdata = count;
            OFS_STATUS:  rdata[0] = running;
            OFS_CONTROL: rdata[CTL_MODE_BIT] = (mode_prog == MODE_FREERUN);
            default:     rdata = ZERO_WORD;
        endcase
    end
endmodule

// File: rtl/ictmr_core.sv
// Counting engine of the timer channel. Latches mode and compare value when
// a start is accepted, counts down with reload (interval) or up with wrap
// (free-running), and emits a registered one-cycle interrupt pulse.
// Assumes start_req and stop_req are never high together.
module ictmr_core
    import ictmr_pkg::*;
#(
    parameter int DATA_W = TMR_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic [DATA_W-1:0] cmp_prog,
    input  tmr_mode_e         mode_prog,
    output logic [DATA_W-1:0] count,
    output logic              running,
    output tmr_mode_e         mode_act,
    output logic              irq
);
    localparam logic [DATA_W-1:0] ZERO_WORD = '0;
    localparam logic [DATA_W-1:0] ONE_WORD  = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] cmp_act;
    logic              at_event;

    // Event condition of the active mode, evaluated on the current count.
    always_comb begin
        if (mode_act == MODE_INTERVAL) at_event = (count == ZERO_WORD);
        else                           at_event = (count == cmp_act);
    end

    // Run state, active setting, counter and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            mode_act <= MODE_INTERVAL;
            cmp_act  <= ZERO_WORD;
            count    <= ZERO_WORD;
            irq      <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (stop_req) begin
                running <= 1'b0;
            end else if (start_req && !running) begin
                running  <= 1'b1;
                mode_act <= mode_prog;
                cmp_act  <= cmp_prog;
                count    <= (mode_prog == MODE_FREERUN) ? ZERO_WORD : cmp_prog;
            end else if (running) begin
                irq <= at_event;
                if (mode_act == MODE_FREERUN) count <= count + ONE_WORD;
                else if (at_event)            count <= cmp_act;
                else                          count <= count - ONE_WORD;
            end
        end
    end
endmodule

// File: rtl/ictmr_channel.sv
// Top of the interval/compare timer channel: register window plus counting
// engine. Reads are combinational; writes and triggers act on the next edge.
module ictmr_channel
    import ictmr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [TMR_ADDR_W-1:0] bus_addr,
    input  logic [TMR_DATA_W-1:0] bus_wdata,
    output logic [TMR_DATA_W-1:0] bus_rdata,
    output logic                  tick_irq
);
    logic [TMR_DATA_W-1:0] cmp_w;
    logic [TMR_DATA_W-1:0] cnt_w;
    tmr_mode_e             mode_prog_w;
    tmr_mode_e             mode_act_w;
    logic                  start_w;
    logic                  stop_w;
    logic                  run_w;

    ictmr_regs #(.DATA_W(TMR_DATA_W), .ADDR_W(TMR_ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .count     (cnt_w),
        .running   (run_w),
        .cmp_prog  (cmp_w),
        .mode_prog (mode_prog_w),
        .start_req (start_w),
        .stop_req  (stop_w),
        .rdata     (bus_rdata)
    );

    ictmr_core #(.DATA_W(TMR_DATA_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_w),
        .stop_req  (stop_w),
        .cmp_prog  (cmp_w),
        .mode_prog (mode_prog_w),
        .count     (cnt_w),
        .running   (run_w),
        .mode_act  (mode_act_w),
        .irq       (tick_irq)
    );
endmodule

// File: rtl/ictmr_checker.sv
// Cycle-level properties of the timer channel, bound into the top module.
module ictmr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        irq,
    input logic        running,
    input logic [31:0] count,
    input logic        mode_act,
    input logic        start_req,
    input logic        stop_req
);
    // Reset leaves the channel stopped with no interrupt.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!running && !irq));

    // A stop trigger halts the counter and suppresses the interrupt.
    assert_stop_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> (!running && !irq));

    // A stopped counter without a start holds its value.
    assert_stopped_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start_req) |=> $stable(count));

    // Interval mode: a nonzero count steps down by one, start writes ignored (R10).
    assert_interval_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !mode_act && !stop_req && count != 32'd0)
            |=> (count == $past(count) - 32'd1));

    // Free-running mode: the count steps up by one, start writes ignored (R10).
    assert_freerun_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && mode_act && !stop_req) |=> (count == $past(count) + 32'd1));

    // An interrupt pulse only follows a running cycle (R7, R9).
    assert_irq_after_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(running));
endmodule

bind ictmr_channel ictmr_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (tick_irq),
    .running   (run_w),
    .count     (cnt_w),
    .mode_act  (mode_act_w),
    .start_req (start_w),
    .stop_req  (stop_w)
);

// File: tb/ictmr_channel_bench.sv
module ictmr_channel_bench;
    localparam logic [5:0] A_CMP = 6'h00, A_CNT = 6'h04, A_STS = 6'h10,
                           A_GO = 6'h14, A_HALT = 6'h18, A_CTL = 6'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = 6'h00;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        tick_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    ictmr_channel u_ictmr_channel (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_irq(tick_irq)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the following negedge.
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    // Expected count k edges after the start edge.
    function automatic logic [31:0] exp_cnt(input bit fr, input int unsigned c, input int unsigned k);
        if (fr) return k;
        return c - (k % (c + 1));
    endfunction

    function automatic logic [31:0] exp_irq(input bit fr, input int unsigned c, input int unsigned k);
        if (k == 0) return 0;
        if (fr) return ((k - 1) == c) ? 32'd1 : 32'd0;
        return ((k % (c + 1)) == 0) ? 32'd1 : 32'd0;
    endfunction

    task automatic start_ch(input bit fr, input logic [31:0] c);
        wr(A_CMP, c);
        wr(A_CTL, fr ? 32'h2 : 32'h0);
        wr(A_GO, 32'h1);
    endtask

    // Observe from k0 to k1-1; ends at the negedge for k1.
    task automatic observe(input bit fr, input int unsigned c, input int unsigned k0, input int unsigned k1);
        logic [31:0] v;
        for (int unsigned k = k0; k < k1; k++) begin
            rd(A_CNT, v);
            check(fr ? "R8 count" : "R6 count", v, exp_cnt(fr, c, k));
            check(fr ? "R9 irq" : "R7 irq", {31'd0, tick_irq}, exp_irq(fr, c, k));
            rd(A_STS, v);
            check("R3 status running", v, 32'd1);
            @(negedge clk);
        end
    endtask

    // Stop at k edges after start; the count freezes at its value for k.
    task automatic stop_ch(input bit fr, input int unsigned c, input int unsigned k);
        logic [31:0] v;
        wr(A_HALT, 32'h1);
        rd(A_STS, v);
        check("R3 status stopped", v, 32'd0);
        for (int i = 0; i < 3; i++) begin
            rd(A_CNT, v);
            check("R5 count held", v, exp_cnt(fr, c, k));
            check("R5 irq low", {31'd0, tick_irq}, 32'd0);
            @(negedge clk);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(A_CMP, v); check("R1 compare", v, 0);
        rd(A_CNT, v); check("R1 count", v, 0);
        rd(A_STS, v); check("R1 status", v, 0);
        rd(A_CTL, v); check("R1 control", v, 0);
        check("R1 irq", {31'd0, tick_irq}, 0);
        // R2: register read-back
        wr(A_CMP, 32'hDEADBEEF); rd(A_CMP, v); check("R2 compare", v, 32'hDEADBEEF);
        wr(A_CTL, 32'hFF); rd(A_CTL, v); check("R2 control mask", v, 32'h2);
        wr(A_CTL, 32'h0); rd(A_CTL, v); check("R2 control clear", v, 32'h0);
        // R4: start write with bit 0 clear does nothing
        wr(A_GO, 32'hFE);
        rd(A_STS, v); check("R4 no start", v, 0);
        rd(A_CNT, v); check("R4 count idle", v, 0);
        // Directed interval runs (R6, R7)
        start_ch(1'b0, 3);  observe(1'b0, 3, 0, 13); stop_ch(1'b0, 3, 13);
        start_ch(1'b0, 0);  observe(1'b0, 0, 0, 6);  stop_ch(1'b0, 0, 6);
        // Directed free-running runs (R8, R9): counts past the match
        start_ch(1'b1, 4);  observe(1'b1, 4, 0, 16); stop_ch(1'b1, 4, 16);
        start_ch(1'b1, 0);  observe(1'b1, 0, 0, 5);  stop_ch(1'b1, 0, 5);
        // R10: writes and a start during a run leave the active setting
        start_ch(1'b0, 5);
        observe(1'b0, 5, 0, 4);
        wr(A_CMP, 32'd99);
        wr(A_CTL, 32'h2);
        wr(A_GO, 32'h1);
        observe(1'b0, 5, 7, 20);
        stop_ch(1'b0, 5, 20);
        rd(A_CMP, v); check("R10 compare kept for next start", v, 32'd99);
        wr(A_GO, 32'h1);
        observe(1'b1, 99, 0, 6);
        stop_ch(1'b1, 99, 6);
        // Random runs
        for (int t = 0; t < 20; t++) begin
            bit fr;
            int unsigned c, len;
            fr  = $urandom % 2;
            c   = $urandom % 24;
            len = 8 + ($urandom % 40);
            start_ch(fr, c);
            observe(fr, c, 0, len);
            stop_ch(fr, c, len);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule